// File: doc/BRIEF.md
# Key Hierarchy Stage Sequencer

This block steps a secure key hierarchy through a fixed order of stages under software command. Software writes a 3-bit operation code and then writes 1 to a start strobe. The block either finishes the command at once (disable, or a command that is not legal in the current stage) or sends a derivation request to an external engine and waits for its done handshake. Progress is reported as a working-state code, a 2-bit operation status and an operation-done interrupt pulse.

While a command is in flight the configuration-enable output is low, so the surrounding register file can lock its control fields. The block also owns the write enable of the software-binding registers. Software may drop that enable, and only a successful stage advance raises it again. Local fault flags, an internal check of the state encoding, or a global escalation input force a terminal invalid state. A derivation result that is all zeros or all ones is treated as a fatal output fault. The disabled state is also terminal, and only reset leaves either terminal state.

Top module: `keyhier_stage_ctrl`

## Requirements
- R1: After reset the working state is 0 (Reset), the status is 0 (idle), the config enable and the binding write enable are 1, and the request, interrupt, invalid-op and output-fault outputs are 0.
- R2: A command begins only when start_we_i is high with start_val_i = 1 while config enable is 1. A start with value 0, or a start while a command is in flight, has no effect.
- R3: From the cycle after an accepted start until completion, config enable reads 0 and the status reads 1 (in progress).
- R4: Advance (op 0) in states 0 to 3 raises drv_req_o with drv_kind_o = 0 one cycle after the start is accepted. The request is held until drv_done_i. A good result moves the state 0→1→2→3→4. drv_done_i is ignored while no request is open.
- R5: Advance in state 4 (Owner Key) behaves like Disable. It issues no request, moves to state 5 (Disabled) and completes with status 2.
- R6: Op codes 4 to 7 issue no request, move states 0 to 4 to state 5 and complete with status 2.
- R7: Generate ops 1, 2 and 3 (identity, software output, hardware output) in states 2 to 4 raise a request with drv_kind_o equal to the op code. On a good result the state is unchanged and the status becomes 2.
- R8: Generate ops in states 0 or 1, and any op in state 5 or 6, complete without a request with status 3 and set err_inv_op_o.
- R9: A derivation result of all zeros or all ones moves the state to 6 (Invalid), completes with status 3 and sets out_fault_o.
- R10: Any fault_i bit or esc_i moves the state to 6 in the next cycle. An in-flight command completes with status 3 and its request drops. State 6 is never left except by reset.
- R11: Each completion raises op_done_o for exactly one cycle, in the same cycle as the final status.
- R12: While idle, writing 1s to status_clr_i clears the matching status bits, and err_clr_i clears err_inv_op_o.
- R13: bind_clr_i drops bind_we_o to 0. Only a successful advance to states 1 to 4 sets it back to 1. Generate, disable and failed operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_we_i | input | 1 | Start register write strobe |
| start_val_i | input | 1 | Start write data; 1 requests a command |
| op_code_i | input | 3 | Operation code sampled at start |
| status_clr_i | input | 2 | Write-1-to-clear mask for status |
| err_clr_i | input | 1 | Clears the invalid-operation bit |
| bind_clr_i | input | 1 | Software write of 0 to the binding enable |
| fault_i | input | NUM_FAULTS | Local fault flags |
| esc_i | input | 1 | Global escalation |
| drv_req_o | output | 1 | Derivation request, held until done |
| drv_kind_o | output | 2 | Derivation kind: 0 advance, 1 id, 2 sw, 3 hw |
| drv_done_i | input | 1 | Derivation done |
| drv_data_i | input | DRV_W | Derivation result, valid with done |
| work_state_o | output | 3 | Working state code 0..6 |
| op_status_o | output | 2 | 0 idle, 1 busy, 2 ok, 3 error |
| cfg_en_o | output | 1 | Configuration enable, 0 while busy |
| op_done_o | output | 1 | Operation-done interrupt pulse |
| err_inv_op_o | output | 1 | Sticky invalid-operation error |
| out_fault_o | output | 1 | Sticky fatal derivation-output fault |
| bind_we_o | output | 1 | Software-binding write enable |

## Verification
The main function is driven with every op code in every reachable stage. Seeded random commands and results are mixed with directed runs along the full advance chain. This separates stage-dependent acceptance (derive, disable or reject) from the effect of the result on state and status. Results equal to all zeros or all ones are injected to separate the output-fault path from an ordinary failure. Starts with value 0, starts while busy and stray done pulses confirm that the command path only listens when it should. Escalation during a pending request and a fault while idle separate abort-with-error from a silent move to Invalid.

// File: rtl/keyhier_pkg.sv
// Shared types and constants of the key hierarchy stage sequencer.
// Assumes a 3-bit operation code and a 3-bit working-state readout.
package keyhier_pkg;
    localparam int STATE_W = 6;
    localparam int WCODE_W = 3;
    localparam int OP_W    = 3;

    // Sparse stage encoding; any other pattern is an integrity fault
    typedef enum logic [STATE_W-1:0] {
        ST_RESET    = 6'b001011,
        ST_INIT     = 6'b010101,
        ST_CREATOR  = 6'b100110,
        ST_OWNINT   = 6'b111000,
        ST_OWNER    = 6'b011110,
        ST_DISABLED = 6'b101101,
        ST_INVALID  = 6'b110011
    } stage_e;

    typedef enum logic [1:0] {ACT_DERIVE, ACT_DISABLE, ACT_REJECT} act_e;
    typedef enum logic [1:0] {PH_IDLE, PH_DECODE, PH_WAIT} phase_e;

    localparam logic [OP_W-1:0] OP_ADVANCE = 3'd0;
    localparam logic [OP_W-1:0] OP_GEN_HW  = 3'd3;

    localparam logic [1:0] OPS_IDLE = 2'd0;
    localparam logic [1:0] OPS_BUSY = 2'd1;
    localparam logic [1:0] OPS_OK   = 2'd2;
    localparam logic [1:0] OPS_ERR  = 2'd3;

    // Map a stage to the software-visible working-state code
    function automatic logic [WCODE_W-1:0] stage_code(stage_e s);
        case (s)
            ST_RESET:    return 3'd0;
            ST_INIT:     return 3'd1;
            ST_CREATOR:  return 3'd2;
            ST_OWNINT:   return 3'd3;
            ST_OWNER:    return 3'd4;
            ST_DISABLED: return 3'd5;
            default:     return 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/keyhier_op_decode.sv
// Decides, from the current stage and the latched op code, whether the command
// derives, disables or is rejected, and which stage it leads to.
// Assumes stage_i is stable for the whole command.
module keyhier_op_decode
    import keyhier_pkg::*;
(
    input  stage_e          stage_i,
    input  logic [OP_W-1:0] op_i,
    output act_e            act_o,
    output stage_e          nxt_o,
    output logic            adv_o
);
    logic gen_ok;
    logic live;

    // Classify the current stage
    always_comb begin
        gen_ok = (stage_i == ST_CREATOR) || (stage_i == ST_OWNINT) || (stage_i == ST_OWNER);
        live   = gen_ok || (stage_i == ST_RESET) || (stage_i == ST_INIT);
    end

    // Command action and successor stage
    always_comb begin
        act_o = ACT_REJECT;
        nxt_o = stage_i;
        adv_o = 1'b0;
        if (live) begin
            if (op_i == OP_ADVANCE) begin
                adv_o = 1'b1;
                act_o = ACT_DERIVE;
                case (stage_i)
                    ST_RESET:   nxt_o = ST_INIT;
                    ST_INIT:    nxt_o = ST_CREATOR;
                    ST_CREATOR: nxt_o = ST_OWNINT;
                    ST_OWNINT:  nxt_o = ST_OWNER;
                    default: begin
                        adv_o = 1'b0;
                        act_o = ACT_DISABLE;
                        nxt_o = ST_DISABLED;
                    end
                endcase
            end else if (op_i <= OP_GEN_HW) begin
                act_o = gen_ok ? ACT_DERIVE : ACT_REJECT;
            end else begin
                act_o = ACT_DISABLE;
                nxt_o = ST_DISABLED;
            end
        end
    end
endmodule

// File: rtl/keyhier_stage_reg.sv
// Holds the sparse stage register, flags illegal encodings and forces the
// terminal invalid stage on kill or on its own encoding fault.
// Assumes upd_i is only raised for legal successor stages.
module keyhier_stage_reg
    import keyhier_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill_i,
    input  logic               upd_i,
    input  stage_e             nxt_i,
    output stage_e             stage_o,
    output logic [WCODE_W-1:0] code_o,
    output logic               enc_err_o
);
    stage_e stage_q;

    // Detect any pattern outside the legal set
    always_comb begin
        case (stage_q)
            ST_RESET, ST_INIT, ST_CREATOR, ST_OWNINT,
            ST_OWNER, ST_DISABLED, ST_INVALID: enc_err_o = 1'b0;
            default:                           enc_err_o = 1'b1;
        endcase
    end

    // Stage register: faults win over normal updates
    always_ff @(posedge clk) begin
        if (!rst_n)                      stage_q <= ST_RESET;
        else if (kill_i || enc_err_o)    stage_q <= ST_INVALID;
        else if (upd_i)                  stage_q <= nxt_i;
    end

    assign stage_o = stage_q;
    assign code_o  = stage_code(stage_q);
endmodule

// File: rtl/keyhier_bind_lock.sv
// Write enable of the software-binding registers: software clears it,
// hardware sets it only on a successful advance.
module keyhier_bind_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic we_o
);
    // Set has priority over a same-cycle software clear
    always_ff @(posedge clk) begin
        if (!rst_n)     we_o <= 1'b1;
        else if (set_i) we_o <= 1'b1;
        else if (clr_i) we_o <= 1'b0;
    end
endmodule

// File: rtl/keyhier_stage_ctrl.sv
// Top of the key hierarchy stage sequencer: accepts start commands, runs the
// derivation handshake, updates stage, status, error and interrupt outputs.
// Assumes drv_data_i is valid in the cycle drv_done_i is high.
module keyhier_stage_ctrl
    import keyhier_pkg::*;
#(
    parameter int DRV_W      = 32,
    parameter int NUM_FAULTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_we_i,
    input  logic                  start_val_i,
    input  logic [OP_W-1:0]       op_code_i,
    input  logic [1:0]            status_clr_i,
    input  logic                  err_clr_i,
    input  logic                  bind_clr_i,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic                  esc_i,
    output logic                  drv_req_o,
    output logic [1:0]            drv_kind_o,
    input  logic                  drv_done_i,
    input  logic [DRV_W-1:0]      drv_data_i,
    output logic [WCODE_W-1:0]    work_state_o,
    output logic [1:0]            op_status_o,
    output logic                  cfg_en_o,
    output logic                  op_done_o,
    output logic                  err_inv_op_o,
    output logic                  out_fault_o,
    output logic                  bind_we_o
);
    localparam logic [DRV_W-1:0] ALL_ONES = {DRV_W{1'b1}};

    phase_e          phase_q;
    logic [OP_W-1:0] op_q;
    stage_e          stage, dec_nxt, stage_nxt;
    act_e            act;
    logic            dec_adv, enc_err;
    logic            start_ok, abort, done_ok, data_bad, in_decode;
    logic            finish, fin_err, stage_upd, adv_good;

    keyhier_op_decode u_dec (
        .stage_i (stage),
        .op_i    (op_q),
        .act_o   (act),
        .nxt_o   (dec_nxt),
        .adv_o   (dec_adv)
    );

    keyhier_stage_reg u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_i    (abort),
        .upd_i     (stage_upd),
        .nxt_i     (stage_nxt),
        .stage_o   (stage),
        .code_o    (work_state_o),
        .enc_err_o (enc_err)
    );

    keyhier_bind_lock u_bind (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (adv_good),
        .clr_i (bind_clr_i),
        .we_o  (bind_we_o)
    );

    // Command-path control terms
    always_comb begin
        start_ok  = start_we_i && start_val_i && (phase_q == PH_IDLE);
        abort     = (|fault_i) || esc_i || enc_err;
        in_decode = (phase_q == PH_DECODE);
        done_ok   = (phase_q == PH_WAIT) && drv_done_i;
        data_bad  = (drv_data_i == '0) || (drv_data_i == ALL_ONES);
        finish    = (phase_q != PH_IDLE) &&
                    (abort || (in_decode && act != ACT_DERIVE) || done_ok);
        fin_err   = abort || (in_decode && act == ACT_REJECT) || (done_ok && data_bad);
        stage_upd = !abort && ((in_decode && act == ACT_DISABLE) ||
                               (done_ok && (data_bad || dec_adv)));
        stage_nxt = (done_ok && data_bad) ? ST_INVALID : dec_nxt;
        adv_good  = !abort && done_ok && !data_bad && dec_adv;
    end

    // Phase sequencing and op latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_ADVANCE;
        end else begin
            case (phase_q)
                PH_IDLE: if (start_ok) begin
                    phase_q <= PH_DECODE;
                    op_q    <= op_code_i;
                end
                PH_DECODE: phase_q <= (!abort && act == ACT_DERIVE) ? PH_WAIT : PH_IDLE;
                PH_WAIT:   if (abort || drv_done_i) phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Status, sticky error bits and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_status_o  <= OPS_IDLE;
            err_inv_op_o <= 1'b0;
            out_fault_o  <= 1'b0;
            op_done_o    <= 1'b0;
        end else begin
            op_done_o <= finish;
            if (start_ok)                    op_status_o <= OPS_BUSY;
            else if (finish)                 op_status_o <= fin_err ? OPS_ERR : OPS_OK;
            else if (phase_q == PH_IDLE)     op_status_o <= op_status_o & ~status_clr_i;
            if (in_decode && act == ACT_REJECT) err_inv_op_o <= 1'b1;
            else if (err_clr_i)                 err_inv_op_o <= 1'b0;
            if (done_ok && data_bad)            out_fault_o <= 1'b1;
        end
    end

    assign cfg_en_o   = (phase_q == PH_IDLE);
    assign drv_req_o  = (phase_q == PH_WAIT);
    assign drv_kind_o = op_q[1:0];
endmodule

// File: rtl/keyhier_stage_ctrl_chk.sv
// Property checker for the stage sequencer, attached by bind; observes ports only.
module keyhier_stage_ctrl_chk #(
    parameter int DRV_W      = 32,
    parameter int NUM_FAULTS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_we_i,
    input logic                  start_val_i,
    input logic [NUM_FAULTS-1:0] fault_i,
    input logic                  esc_i,
    input logic                  drv_req_o,
    input logic                  drv_done_i,
    input logic [DRV_W-1:0]      drv_data_i,
    input logic [2:0]            work_state_o,
    input logic [1:0]            op_status_o,
    input logic                  cfg_en_o,
    input logic                  op_done_o,
    input logic                  bind_we_o
);
    a_r3_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_o |-> op_status_o == 2'd1);

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req_o && !drv_done_i && !esc_i && !(|fault_i)) |=> drv_req_o);

    a_r6_disabled_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        work_state_o == 3'd5 |=> (work_state_o == 3'd5 || work_state_o == 3'd6));

    a_r7_req_live_stage: assert property (@(posedge clk) disable iff (!rst_n)
        drv_req_o |-> work_state_o <= 3'd4);

    a_r8_terminal_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we_i && start_val_i && cfg_en_o && work_state_o >= 3'd5)
        |=> ##1 op_status_o == 2'd3);

    a_r9_bad_result: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_req_o && drv_done_i && (drv_data_i == '0 || drv_data_i == '1))
        |=> (work_state_o == 3'd6 && op_status_o == 2'd3));

    a_r10_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_i || (|fault_i)) |=> work_state_o == 3'd6);

    a_r10_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        work_state_o == 3'd6 |=> work_state_o == 3'd6);

    a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_o |=> !op_done_o);

    a_r13_bind_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bind_we_o) |-> $past(drv_req_o && drv_done_i));
endmodule

bind keyhier_stage_ctrl keyhier_stage_ctrl_chk #(
    .DRV_W      (DRV_W),
    .NUM_FAULTS (NUM_FAULTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_we_i   (start_we_i),
    .start_val_i  (start_val_i),
    .fault_i      (fault_i),
    .esc_i        (esc_i),
    .drv_req_o    (drv_req_o),
    .drv_done_i   (drv_done_i),
    .drv_data_i   (drv_data_i),
    .work_state_o (work_state_o),
    .op_status_o  (op_status_o),
    .cfg_en_o     (cfg_en_o),
    .op_done_o    (op_done_o),
    .bind_we_o    (bind_we_o)
);

// File: tb/keyhier_stage_ctrl_tb.sv
// Self-checking bench: directed corner cases then seeded random commands,
// compared with a behavioural model kept in bench variables.
module keyhier_stage_ctrl_tb;
    localparam int DW = 32;
    localparam int NF = 4;
    localparam int A_DERIVE = 0, A_DISABLE = 1, A_REJECT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_we = 1'b0, start_val = 1'b0;
    logic [2:0]    op_code = '0;
    logic [1:0]    status_clr = '0;
    logic          err_clr = 1'b0, bind_clr = 1'b0, esc = 1'b0, drv_done = 1'b0;
    logic [NF-1:0] fault = '0;
    logic [DW-1:0] drv_data = '0;
    logic          drv_req, cfg_en, op_done, err_inv, ofault, bind_we;
    logic [1:0]    drv_kind, op_status;
    logic [2:0]    work_state;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int m_stage;
    bit m_err, m_bind, m_ofault;

    always #5 clk = ~clk;

    keyhier_stage_ctrl #(.DRV_W(DW), .NUM_FAULTS(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_we_i(start_we), .start_val_i(start_val),
        .op_code_i(op_code), .status_clr_i(status_clr), .err_clr_i(err_clr),
        .bind_clr_i(bind_clr), .fault_i(fault), .esc_i(esc),
        .drv_req_o(drv_req), .drv_kind_o(drv_kind), .drv_done_i(drv_done),
        .drv_data_i(drv_data), .work_state_o(work_state), .op_status_o(op_status),
        .cfg_en_o(cfg_en), .op_done_o(op_done), .err_inv_op_o(err_inv),
        .out_fault_o(ofault), .bind_we_o(bind_we)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_action(input int st, input logic [2:0] op);
        if (st >= 5) return A_REJECT;
        if (op == 3'd0) return (st == 4) ? A_DISABLE : A_DERIVE;
        if (op <= 3'd3) return (st >= 2) ? A_DERIVE : A_REJECT;
        return A_DISABLE;
    endfunction

    function automatic bit is_bad(input logic [DW-1:0] d);
        return (d == '0) || (d == '1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_stage = 0; m_err = 0; m_bind = 1; m_ofault = 0;
        chk("R1", "state", work_state, 0);
        chk("R1", "status", op_status, 0);
        chk("R1", "cfg_en", cfg_en, 1);
        chk("R1", "bind_we", bind_we, 1);
        chk("R1", "req/irq/err/fault", {drv_req, op_done, err_inv, ofault}, 0);
    endtask

    task automatic final_checks(input string tag, input logic [1:0] exp_st);
        chk(tag, "status", op_status, exp_st);
        chk("R11", "irq at completion", op_done, 1);
        chk(tag, "cfg_en", cfg_en, 1);
        chk(tag, "req", drv_req, 0);
        chk(tag, "state", work_state, m_stage);
        chk(tag, "err", err_inv, m_err);
        chk(tag, "out fault", ofault, m_ofault);
        chk("R13", "bind_we", bind_we, m_bind);
        @(negedge clk);
        chk("R11", "irq one cycle", op_done, 0);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [DW-1:0] data,
                          input int lat, input bit poke);
        int act;
        string tag;
        logic [1:0] exp_st;
        act = exp_action(m_stage, op);
        if (act == A_DERIVE)       tag = (op == 0) ? "R4" : "R7";
        else if (act == A_DISABLE) tag = (op == 0) ? "R5" : "R6";
        else                       tag = "R8";
        start_we = 1; start_val = 1; op_code = op;
        @(negedge clk);
        start_we = 0; start_val = 0;
        chk("R3", "busy cfg/status", {cfg_en, op_status}, {1'b0, 2'd1});
        @(negedge clk);
        if (act == A_DERIVE) begin
            chk(tag, "req", drv_req, 1);
            chk(tag, "kind", drv_kind, op[1:0]);
            if (poke) begin start_we = 1; start_val = 1; op_code = 3'd4; end
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                start_we = 0; start_val = 0;
                chk("R4", "req held", drv_req, 1);
            end
            drv_done = 1; drv_data = data;
            @(negedge clk);
            drv_done = 0;
            if (is_bad(data)) begin
                tag = "R9"; m_stage = 6; m_ofault = 1; exp_st = 2'd3;
            end else begin
                exp_st = 2'd2;
                if (op == 0) begin m_stage++; m_bind = 1; end
            end
        end else begin
            chk(tag, "no req", drv_req, 0);
            if (act == A_DISABLE) begin m_stage = 5; exp_st = 2'd2; end
            else begin m_err = 1; exp_st = 2'd3; end
        end
        final_checks(tag, exp_st);
    endtask

    task automatic clear_status(input bit also_err);
        status_clr = 2'b11; err_clr = also_err;
        @(negedge clk);
        status_clr = 0; err_clr = 0;
        if (also_err) m_err = 0;
        chk("R12", "status cleared", op_status, 0);
        chk("R12", "err bit", err_inv, m_err);
    endtask

    task automatic bind_clear();
        bind_clr = 1;
        @(negedge clk);
        bind_clr = 0;
        m_bind = 0;
        chk("R13", "bind cleared", bind_we, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [2:0] op;
        void'($urandom(32'h5eed_0b1d));
        @(negedge clk);
        do_reset();

        // R2: start with value 0 is ignored
        start_we = 1; start_val = 0; op_code = 3'd0;
        @(negedge clk);
        start_we = 0;
        @(negedge clk);
        chk("R2", "value 0 ignored", {cfg_en, op_status, drv_req}, {1'b1, 2'd0, 1'b0});

        // R4: stray done while idle is ignored
        drv_done = 1; drv_data = '0;
        @(negedge clk);
        drv_done = 0;
        chk("R4", "stray done state", work_state, 0);
        chk("R4", "stray done fault", ofault, 0);

        run_op(3'd1, 32'h1234_5678, 0, 0);          // reject in Reset
        clear_status(1);
        run_op(3'd0, 32'hcafe_0001, 2, 0);          // -> Init
        run_op(3'd2, 32'hcafe_0002, 0, 0);          // reject in Init
        run_op(3'd0, 32'hcafe_0003, 1, 0);          // -> Creator
        bind_clear();
        run_op(3'd2, 32'hcafe_0004, 3, 0);          // gen sw, bind stays 0
        run_op(3'd0, 32'hcafe_0005, 0, 0);          // -> OwnInt, bind back to 1
        run_op(3'd1, 32'hcafe_0006, 3, 1);          // R2: start while busy ignored
        chk("R2", "busy start no effect", work_state, 3);
        run_op(3'd3, 32'hcafe_0007, 0, 0);
        run_op(3'd0, 32'hcafe_0008, 0, 0);          // -> Owner
        run_op(3'd0, 32'hcafe_0009, 0, 0);          // R5 -> Disabled
        run_op(3'd1, 32'hcafe_000a, 0, 0);          // reject in Disabled

        do_reset();
        run_op(3'd0, 32'h0000_0011, 0, 0);
        run_op(3'd6, 32'h0, 0, 0);                  // R6 code 6 disables

        do_reset();
        run_op(3'd0, 32'h0, 1, 0);                  // R9 all zeros
        do_reset();
        run_op(3'd0, '1, 0, 0);                     // R9 all ones
        run_op(3'd4, 32'h1, 0, 0);                  // reject in Invalid

        // R10: escalation during a pending request
        do_reset();
        run_op(3'd0, 32'h77, 0, 0);
        run_op(3'd0, 32'h78, 0, 0);
        start_we = 1; start_val = 1; op_code = 3'd1;
        @(negedge clk);
        start_we = 0; start_val = 0;
        @(negedge clk);
        chk("R10", "req before esc", drv_req, 1);
        esc = 1;
        @(negedge clk);
        esc = 0;
        m_stage = 6;
        final_checks("R10", 2'd3);

        // R10: local fault while idle, no completion pulse
        do_reset();
        run_op(3'd0, 32'h99, 0, 0);
        clear_status(0);
        fault = 4'b0100;
        @(negedge clk);
        fault = '0;
        chk("R10", "fault idle state", work_state, 6);
        chk("R10", "fault idle status", op_status, 0);
        chk("R10", "fault idle irq", op_done, 0);
        @(negedge clk);
        chk("R10", "invalid terminal", work_state, 6);

        // Seeded random commands
        do_reset();
        for (int n = 0; n < 400; n++) begin
            if (m_stage >= 5 && $urandom_range(0, 2) == 0) do_reset();
            op = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd0;
            if ($urandom_range(0, 1) == 1 && m_stage >= 2) op = 3'($urandom_range(1, 3));
            d = $urandom;
            if (is_bad(d)) d = 32'h5a5a_0001;
            if ($urandom_range(0, 15) == 0) d = $urandom_range(0, 1) ? '0 : '1;
            run_op(op, d, $urandom_range(0, 4), 1'b0);
            if ($urandom_range(0, 1) == 0) clear_status($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 7) == 0) bind_clear();
        end

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule